// File: doc/BRIEF.md
# Video Address Edge Scanline Interrupt Counter

This block turns rising edges of video address bit 12 into a programmable interrupt. Rendering normally fetches background tiles from one half of pattern memory and sprite tiles from the other, which produces one low-to-high transition of bit 12 per line. The block counts these transitions with an 8-bit down-counter and raises an interrupt request when the count runs out. Software sets up the line-based behaviour by choosing the pattern halves. The counter has no other time base.

The processor programs the block through byte writes. The bus decode supplies a 2-bit window index, which is address bits 14:13 of the upper 32 KB. It also supplies address bit 0 and the data byte. Window 2 holds the reload value (even address) and the deferred reload request (odd address). Window 3 holds the disable-and-acknowledge command (even address) and the enable command (odd address). Windows 0 and 1 belong to other logic. A low-time qualifier drops rising edges that follow only a short low period on bit 12.

Top module: `scanline_irq_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `irq_req` is 0, and the counter, reload value, reload request and enable are all cleared. The qualifier starts as if bit 12 had already been low long enough, so the first high sample after reset counts as a qualified edge.
- R2: A write with `cpu_wr_window` = 2 and `cpu_wr_a0` = 0 stores `cpu_wr_data` as the reload value.
- R3: A write with `cpu_wr_window` = 2 and `cpu_wr_a0` = 1 sets a reload request, whatever the data. At the next qualified edge the counter loads the reload value, and the request clears.
- R4: A write with `cpu_wr_window` = 3 and `cpu_wr_a0` = 1 enables the interrupt. A write with `cpu_wr_window` = 3 and `cpu_wr_a0` = 0 disables it, and `irq_req` is low from the following cycle.
- R5: At a qualified edge with no reload request, a nonzero counter drops by one. A counter already at zero loads the reload value instead. Between qualified edges the counter holds.
- R6: When a qualified edge leaves the counter at zero while the interrupt is enabled, `irq_req` goes high after that clock edge. It stays high until a disable write. With a reload value of N > 0, set up by a reload request, the interrupt comes at qualified edge N+1, and again every N+1 edges after each acknowledge and re-enable.
- R7: A rising edge of `vid_a12` is qualified only if `vid_a12` was sampled low on at least FILTER_CYCLES consecutive clocks before the high sample. Any other rising edge leaves the counter unchanged.
- R8: With a reload value of 0, every qualified edge leaves the counter at zero and raises the interrupt while it is enabled.
- R9: Writes with `cpu_wr_window` = 0 or 1 change no state of the block.
- R10: Reaching zero while disabled raises no interrupt. Enabling afterwards does not raise one retroactively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_a12 | input | 1 | Video address bit 12, synchronous to clk |
| cpu_wr_en | input | 1 | One-cycle processor write strobe |
| cpu_wr_window | input | 2 | Window index of the write (address bits 14:13) |
| cpu_wr_a0 | input | 1 | Address bit 0 of the write |
| cpu_wr_data | input | 8 | Write data |
| irq_req | output | 1 | Interrupt request, active high, level |

## Verification
All internal state reaches the ports only through the timing of `irq_req`. A wrong reload value, a lost reload request or a wrong decrement shows as the interrupt arriving at the wrong qualified edge, or not at all, within one count period. A qualifier that passes short low periods makes the interrupt fire early, at the first stray edge that should have been dropped. The bench compares `irq_req` with an arithmetic model on every cycle while it sweeps the reload values and the low-period lengths. The mismatch therefore shows on the cycle after the edge that went wrong.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

   // Processor-side window index (address bits 14:13 within the upper 32 KB)
   typedef enum logic [1:0] {
      WIN_BANK     = 2'd0,
      WIN_MIRROR   = 2'd1,
      WIN_IRQ_LOAD = 2'd2,
      WIN_IRQ_CTRL = 2'd3
   } cpu_window_e;

   // Decoded one-cycle commands for the counter
   typedef struct packed {
      logic set_latch;
      logic req_reload;
      logic irq_on;
      logic irq_off;
   } irq_cmd_t;

   localparam irq_cmd_t IRQ_CMD_NONE = '{default: 1'b0};

endpackage

// File: rtl/scanirq_wr_decode.sv
module scanirq_wr_decode
   import scanirq_pkg::*;
(
   input  logic       wr_en,
   input  logic [1:0] wr_window,
   input  logic       wr_a0,
   output irq_cmd_t   cmd
);

   cpu_window_e win;

   always_comb begin
      win = cpu_window_e'(wr_window);
      cmd = IRQ_CMD_NONE;
      if (wr_en) begin
         unique case (win)
            WIN_IRQ_LOAD: begin
               cmd.set_latch  = ~wr_a0;
               cmd.req_reload = wr_a0;
            end
            WIN_IRQ_CTRL: begin
               cmd.irq_off = ~wr_a0;
               cmd.irq_on  = wr_a0;
            end
            default: cmd = IRQ_CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/scanirq_a12_qualifier.sv
module scanirq_a12_qualifier #(
   parameter bit          FILTER_EN     = 1'b1,
   parameter int unsigned FILTER_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a12,
   output logic tick
);

   localparam int unsigned LOW_W = $clog2(FILTER_CYCLES + 1);
   localparam logic [LOW_W-1:0] LOW_LIMIT = LOW_W'(FILTER_CYCLES);

   logic a12_q;

   // Reset state: line seen low, so a first high sample is a rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a12_q <= 1'b0;
      else        a12_q <= a12;
   end

   generate
      if (FILTER_EN) begin : g_filter
         logic [LOW_W-1:0] low_run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_run_q <= LOW_LIMIT;
            else if (a12)
               low_run_q <= '0;
            else if (low_run_q != LOW_LIMIT)
               low_run_q <= low_run_q + 1'b1;
         end

         assign tick = a12 & ~a12_q & (low_run_q == LOW_LIMIT);
      end else begin : g_raw
         assign tick = a12 & ~a12_q;
      end
   endgenerate

endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter
   import scanirq_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  irq_cmd_t          cmd,
   input  logic [DATA_W-1:0] data,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  latch_o,
   output logic              reload_o,
   output logic              enable_o,
   output logic              irq_o
);

   logic [CNT_W-1:0] cnt_q, cnt_next, latch_q;
   logic             reload_q, en_q, pend_q;
   logic             hit;

   always_comb begin
      cnt_next = cnt_q;
      if (tick) begin
         if (reload_q || (cnt_q == '0)) cnt_next = latch_q;
         else                           cnt_next = cnt_q - 1'b1;
      end
      hit = tick & (cnt_next == '0) & en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         latch_q  <= '0;
         reload_q <= 1'b0;
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         cnt_q <= cnt_next;
         if (cmd.set_latch) latch_q <= data[CNT_W-1:0];
         if (cmd.req_reload) reload_q <= 1'b1;
         else if (tick)      reload_q <= 1'b0;
         if (cmd.irq_on)       en_q <= 1'b1;
         else if (cmd.irq_off) en_q <= 1'b0;
         if (cmd.irq_off) pend_q <= 1'b0;
         else if (hit)    pend_q <= 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign latch_o  = latch_q;
   assign reload_o = reload_q;
   assign enable_o = en_q;
   assign irq_o    = pend_q;

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
   import scanirq_pkg::*;
#(
   parameter int unsigned CNT_W         = 8,
   parameter int unsigned DATA_W        = 8,
   parameter bit          FILTER_EN     = 1'b1,
   parameter int unsigned FILTER_CYCLES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vid_a12,
   input  logic              cpu_wr_en,
   input  logic [1:0]        cpu_wr_window,
   input  logic              cpu_wr_a0,
   input  logic [DATA_W-1:0] cpu_wr_data,
   output logic              irq_req
);

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (CNT_W <= DATA_W) else $error("CNT_W must not exceed DATA_W");
      assert (FILTER_CYCLES >= 1) else $error("FILTER_CYCLES must be at least 1");
   end

   irq_cmd_t         cmd;
   logic             edge_tick;
   logic [CNT_W-1:0] cnt_q, latch_q;
   logic             reload_q, en_q;

   scanirq_wr_decode u_decode (
      .wr_en     (cpu_wr_en),
      .wr_window (cpu_wr_window),
      .wr_a0     (cpu_wr_a0),
      .cmd       (cmd)
   );

   scanirq_a12_qualifier #(
      .FILTER_EN     (FILTER_EN),
      .FILTER_CYCLES (FILTER_CYCLES)
   ) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .a12   (vid_a12),
      .tick  (edge_tick)
   );

   scanirq_counter #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (edge_tick),
      .cmd      (cmd),
      .data     (cpu_wr_data),
      .cnt_o    (cnt_q),
      .latch_o  (latch_q),
      .reload_o (reload_q),
      .enable_o (en_q),
      .irq_o    (irq_req)
   );

endmodule

// File: rtl/scanirq_checker.sv
module scanirq_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_window,
   input logic             wr_a0,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] latch,
   input logic             reload,
   input logic             enable,
   input logic             irq
);

   logic ack_wr, on_wr, foreign_wr;
   assign ack_wr     = wr_en && (wr_window == 2'd3) && !wr_a0;
   assign on_wr      = wr_en && (wr_window == 2'd3) && wr_a0;
   assign foreign_wr = wr_en && (wr_window[1] == 1'b0);

   assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !irq);

   assert_reload_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (reload || cnt == '0) |=> cnt == $past(latch));

   assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !reload && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

   assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      on_wr |=> enable);

   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !irq && !enable);

   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack_wr |=> irq);

   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick) && $past(enable));

   assert_foreign_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_wr |=> $stable(latch) && $stable(enable));

endmodule

bind scanline_irq_unit scanirq_checker #(.CNT_W(CNT_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (cpu_wr_en),
   .wr_window (cpu_wr_window),
   .wr_a0     (cpu_wr_a0),
   .tick      (edge_tick),
   .cnt       (cnt_q),
   .latch     (latch_q),
   .reload    (reload_q),
   .enable    (en_q),
   .irq       (irq_req)
);

// File: tb/test_scanline_irq_unit.sv
module test_scanline_irq_unit;

   localparam int F = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vid_a12 = 1'b1;
   logic       cpu_wr_en = 1'b0;
   logic [1:0] cpu_wr_window = 2'd0;
   logic       cpu_wr_a0 = 1'b0;
   logic [7:0] cpu_wr_data = 8'd0;
   logic       irq_req;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // Arithmetic model state
   int m_cnt = 0, m_latch = 0, m_flag = 0, m_en = 0, m_pend = 0;
   int m_low = F, m_prev = 0;
   logic cur_a12 = 1'b1;

   always #5 clk = ~clk;

   scanline_irq_unit #(
      .CNT_W(8), .DATA_W(8), .FILTER_EN(1'b1), .FILTER_CYCLES(F)
   ) i_scanline_irq_unit (
      .clk(clk), .rst_n(rst_n), .vid_a12(vid_a12),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_window(cpu_wr_window),
      .cpu_wr_a0(cpu_wr_a0), .cpu_wr_data(cpu_wr_data),
      .irq_req(irq_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic model_edge(input logic a12, input logic we, input logic [1:0] win,
                             input logic a0, input logic [7:0] d);
      int tick, nc;
      tick = (a12 && !m_prev && m_low >= F) ? 1 : 0;
      m_low  = a12 ? 0 : ((m_low < F) ? m_low + 1 : F);
      m_prev = a12 ? 1 : 0;
      if (tick != 0) begin
         if (m_flag != 0 || m_cnt == 0) nc = m_latch;
         else                           nc = m_cnt - 1;
         m_flag = 0;
         m_cnt  = nc;
         if (nc == 0 && m_en != 0) m_pend = 1;
      end
      if (we && win == 2'd2 && !a0) m_latch = d;
      if (we && win == 2'd2 && a0)  m_flag = 1;
      if (we && win == 2'd3 && a0)  m_en = 1;
      if (we && win == 2'd3 && !a0) begin m_en = 0; m_pend = 0; end
   endtask

   // One clock: compare, drive at negedge, update the model at posedge
   task automatic step(input logic a12, input logic we = 1'b0, input logic [1:0] win = 2'd0,
                       input logic a0 = 1'b0, input logic [7:0] d = 8'd0);
      @(negedge clk);
      chk(irq_req == m_pend[0], cur_req, int'(irq_req), m_pend);
      vid_a12 = a12; cur_a12 = a12;
      cpu_wr_en = we; cpu_wr_window = win; cpu_wr_a0 = a0; cpu_wr_data = d;
      @(posedge clk);
      model_edge(a12, we, win, a0, d);
   endtask

   task automatic wr(input logic [1:0] win, input logic a0, input logic [7:0] d);
      step(cur_a12, 1'b1, win, a0, d);
      step(cur_a12);
   endtask

   task automatic pulse(input int low_len, input int high_len);
      for (int i = 0; i < low_len; i++) step(1'b0);
      for (int i = 0; i < high_len; i++) step(1'b1);
   endtask

   // Number of good pulses until irq_req is seen (0 if never within max)
   task automatic pulses_to_irq(input int max, output int n);
      n = 0;
      for (int p = 1; p <= max; p++) begin
         pulse(F, 3);
         @(negedge clk);
         if (irq_req && n == 0) n = p;
         if (n != 0) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      summary();
      $finish;
   end

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(irq_req == 1'b0, "R1", int'(irq_req), 0);
      rst_n = 1'b1;
      // a12 held high through reset: first sample after release is qualified
      cur_req = "R1";
      step(1'b1);
      step(1'b1);
      chk(irq_req == 1'b0, "R1", int'(irq_req), 0);

      // R2/R3/R5/R6/R8: sweep reload values
      for (int L = 0; L <= 9; L++) begin
         cur_req = "R2";
         wr(2'd2, 1'b0, 8'(L));
         cur_req = "R3";
         wr(2'd2, 1'b1, 8'hA5);
         cur_req = "R4";
         wr(2'd3, 1'b1, 8'h00);
         cur_req = "R6";
         pulses_to_irq(L + 3, n);
         chk(n == L + 1, (L == 0) ? "R8" : "R6", n, L + 1);
         wr(2'd3, 1'b0, 8'h00);
         chk(irq_req == 1'b0, "R4", int'(irq_req), 0);
         wr(2'd3, 1'b1, 8'h00);
         cur_req = "R5";
         pulses_to_irq(L + 3, n);
         chk(n == L + 1, (L == 0) ? "R8" : "R5", n, L + 1);
         wr(2'd3, 1'b0, 8'h00);
      end

      // R7: low-period qualifier sweep
      cur_req = "R7";
      for (int lo = 1; lo <= F + 2; lo++) begin
         wr(2'd2, 1'b0, 8'd1);
         wr(2'd2, 1'b1, 8'd0);
         wr(2'd3, 1'b1, 8'd0);
         pulse(F, 3);                  // loads 1
         for (int k = 0; k < 3; k++) pulse(lo, 3);
         @(negedge clk);
         chk(irq_req == (lo >= F), "R7", int'(irq_req), (lo >= F) ? 1 : 0);
         wr(2'd3, 1'b0, 8'd0);
      end

      // R10: reaching zero while disabled
      cur_req = "R10";
      wr(2'd2, 1'b0, 8'd1);
      wr(2'd2, 1'b1, 8'd0);
      pulse(F, 3);
      pulse(F, 3);                     // counter now zero, disabled
      wr(2'd3, 1'b1, 8'd0);
      pulse(1, 3);                     // unqualified edge
      chk(irq_req == 1'b0, "R10", int'(irq_req), 0);

      // R9: foreign windows ignored
      cur_req = "R9";
      wr(2'd3, 1'b0, 8'd0);
      wr(2'd2, 1'b0, 8'd3);
      wr(2'd2, 1'b1, 8'd0);
      for (int w = 0; w < 2; w++)
         for (int a = 0; a < 2; a++) begin
            wr(2'(w), 1'(a), 8'h00);
            wr(2'(w), 1'(a), 8'hFF);
         end
      chk(irq_req == 1'b0, "R9", int'(irq_req), 0);
      wr(2'd3, 1'b1, 8'd0);
      pulses_to_irq(8, n);
      chk(n == 4, "R9", n, 4);

      step(1'b0);
      summary();
      $finish;
   end

endmodule